// File: doc/BRIEF.md
# Mode-Gated Memory-Card Command Responder

This block answers 8-byte commands from a card host. It keeps a two-bit command mode and decodes each command only against the command set of that mode. The four modes are raw, standard secure, extended secure and main. Because decoding is gated by the mode, a command meant for one mode can never be taken as a command for another. The mode only moves forward: raw, then one of the secure modes, then main. Only reset returns it to raw.

The host offers each command with a strobe. The plain 8 bytes arrive on one bus and the already-decrypted 8 bytes on another. The host also gives a reply length in bytes. The block then sends that many reply bytes, one per handshake. Each reply byte is one of three things:
- filler (0xFF),
- a byte of the 32-bit chip identifier, repeated word after word,
- a byte of a 4 KiB ROM block.

For a ROM block, the block first raises a read request with the block address and waits for the ROM side to acknowledge. During streaming it presents the byte offset within the block and takes the byte back combinationally. The secure modes can also raise a sticky flag that tells the data path to encrypt; the block only raises the flag and does not encrypt anything itself.

Top module: `mc_cmd_responder`

## Requirements
- R1: After reset the mode is raw (0), `data_enc` is 0, `out_valid` and `rd_req` are 0, and `cmd_ready` is 1.
- R2: In raw mode, opcode 0x9F (byte 0 = `cmd_raw[63:56]`) returns `cmd_len` bytes of 0xFF.
- R3: In raw mode, opcode 0x00 requests the ROM block at address 0. Reply byte i is the block byte at offset i mod 4096, so lengths above 4096 repeat the first 4096 bytes.
- R4: A chip-ID reply byte i equals `chip_id[8*(i mod 4)+:8]`. This applies to raw opcode 0x90, secure nibble 0x1 and main opcode 0xB8.
- R5: In raw mode, opcode 0x3C sets the mode to standard secure (1). Opcode 0x3D sets extended secure (2) only when `ext_cap` is 1; otherwise the mode is unchanged.
- R6: In the secure modes, dispatch uses only `cmd_dec[63:60]` and ignores `cmd_raw`. Raw and main modes use only `cmd_raw[63:56]` and ignore `cmd_dec`.
- R7: Secure nibble 0x4 sets `data_enc`, which then stays set until reset. Secure nibble 0xA sets the mode to main (3).
- R8: Secure nibble 0x2 reads one ROM block. In mode 1 its address is `{cmd_dec[47:44],12'h000}`. In mode 2 the address is that value minus 0x1000 plus `region_hdr<<19`, taken modulo 2^32.
- R9: Unknown commands in any mode, and the mode or flag commands, reply with 0xFF filler. Unknown commands leave the mode unchanged. Main mode is left only by reset.
- R10: A byte moves on each cycle with `out_valid && out_ready`, and the byte is held while stalled. `out_last` marks the final byte. A length of 0 gives no reply. `cmd_ready` is 1 only when no reply is pending.
- R11: `rd_req` stays high with a stable `rd_addr` until `rd_done`. No reply byte is offered before that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_raw | input | 64 | Plain command, byte 0 in bits 63:56 |
| cmd_dec | input | 64 | Decrypted command, byte 0 in bits 63:56 |
| cmd_len | input | LEN_W | Reply length in bytes |
| ext_cap | input | 1 | Extended secure mode permitted |
| region_hdr | input | 16 | Header value giving the extended region base |
| chip_id | input | 32 | Chip identifier |
| rd_req | output | 1 | ROM block read request |
| rd_addr | output | ADDR_W | ROM block address |
| rd_done | input | 1 | ROM block ready |
| rom_off | output | BLK_W | Byte offset within the ROM block |
| rom_byte | input | 8 | ROM byte at rom_off |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte taken |
| out_byte | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| mode | output | 2 | Command mode: 0 raw, 1 secure, 2 extended secure, 3 main |
| data_enc | output | 1 | Data encryption flag |

## Verification
Mode and `data_enc` change on the clock edge that accepts the command. A filler or chip-ID reply offers its first byte on that same edge. A ROM reply instead raises `rd_req` on that edge and offers its first byte on the edge that samples `rd_done`. Each later byte, and the return of `cmd_ready` after the last byte, follows the edge on which `out_valid && out_ready` held. The bench model steps on the same edges. It compares every output at the falling edge, half a cycle after the edge that made it due, while `out_ready` stalls at random.

// File: rtl/mc_cmd_responder.sv
module mc_cmd_responder #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [63:0]       cmd_raw,
  input  logic [63:0]       cmd_dec,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              ext_cap,
  input  logic [15:0]       region_hdr,
  input  logic [31:0]       chip_id,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  output logic [BLK_W-1:0]  rom_off,
  input  logic [7:0]        rom_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last,
  output logic [1:0]        mode,
  output logic              data_enc
);
  localparam logic [1:0] M_RAW = 2'd0, M_SEC = 2'd1, M_SECX = 2'd2, M_MAIN = 2'd3;
  localparam logic [1:0] SRC_FILL = 2'd0, SRC_ID = 2'd1, SRC_ROM = 2'd2;
  localparam logic [ADDR_W-1:0] BLK_SIZE = ADDR_W'(1) << BLK_W;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} st_t;

  st_t              st;
  logic [LEN_W-1:0] len_q, cnt;
  logic [1:0]       src_q;

  logic [7:0]        op;
  logic [3:0]        nib;
  logic [ADDR_W-1:0] sec_blk, region_base;
  logic [1:0]        nx_mode, d_src;
  logic              nx_enc, d_rom;
  logic [ADDR_W-1:0] d_addr;

  assign op          = cmd_raw[63:56];
  assign nib         = cmd_dec[63:60];
  assign sec_blk     = ADDR_W'({cmd_dec[47:44], {BLK_W{1'b0}}});
  assign region_base = ADDR_W'({region_hdr, 19'd0});

  wire unused_bits = ^{cmd_raw[55:0], cmd_dec[59:48], cmd_dec[43:0]};

  always_comb begin
    nx_mode = mode;
    nx_enc  = data_enc;
    d_src   = SRC_FILL;
    d_rom   = 1'b0;
    d_addr  = '0;
    case (mode)
      M_RAW: begin
        case (op)
          8'h00: begin d_src = SRC_ROM; d_rom = 1'b1; end
          8'h90: d_src = SRC_ID;
          8'h3C: nx_mode = M_SEC;
          8'h3D: if (ext_cap) nx_mode = M_SECX;
          default: ;
        endcase
      end
      M_SEC, M_SECX: begin
        case (nib)
          4'h1: d_src = SRC_ID;
          4'h2: begin
            d_src  = SRC_ROM;
            d_rom  = 1'b1;
            d_addr = (mode == M_SECX) ? sec_blk - BLK_SIZE + region_base : sec_blk;
          end
          4'h4: nx_enc = 1'b1;
          4'hA: nx_mode = M_MAIN;
          default: ;
        endcase
      end
      default: if (op == 8'hB8) d_src = SRC_ID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode     <= M_RAW;
      data_enc <= 1'b0;
      len_q    <= '0;
      cnt      <= '0;
      src_q    <= SRC_FILL;
      rd_addr  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_valid) begin
          mode     <= nx_mode;
          data_enc <= nx_enc;
          len_q    <= cmd_len;
          cnt      <= '0;
          src_q    <= d_src;
          if (d_rom) rd_addr <= d_addr;
          if (cmd_len == '0) st <= ST_IDLE;
          else if (d_rom)    st <= ST_WAIT;
          else               st <= ST_SEND;
        end
        ST_WAIT: if (rd_done) st <= ST_SEND;
        default: if (out_ready) begin
          if (cnt == len_q - 1'b1) st <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign rd_req    = (st == ST_WAIT);
  assign out_valid = (st == ST_SEND);
  assign out_last  = out_valid && (cnt == len_q - 1'b1);
  assign rom_off   = cnt[BLK_W-1:0];

  always_comb begin
    case (src_q)
      SRC_ID:  out_byte = chip_id[{cnt[1:0], 3'b000} +: 8];
      SRC_ROM: out_byte = rom_byte;
      default: out_byte = 8'hFF;
    endcase
  end

  assert_enc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_enc |=> data_enc);

  assert_main_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_MAIN) |=> (mode == M_MAIN));

  assert_mode_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past(cmd_valid && cmd_ready));

  assert_ext_needs_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SECX && $past(mode) == M_RAW) |-> $past(ext_cap));

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(rom_off)));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));

  assert_no_early_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !out_valid);
endmodule

// File: tb/mc_cmd_responder_test.sv
module mc_cmd_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_raw = '0, cmd_dec = '0;
  logic [15:0] cmd_len = '0;
  logic        ext_cap = 1'b0;
  logic [15:0] region_hdr = 16'h0003;
  logic [31:0] chip_id = 32'hA1B2C3D4;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_done = 1'b0;
  logic [11:0] rom_off;
  logic [7:0]  rom_byte;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_byte;
  logic        out_last;
  logic [1:0]  mode;
  logic        data_enc;

  int checks = 0, errors = 0, cycles = 0;
  logic started = 1'b0;

  always #2.5 clk = ~clk;

  mc_cmd_responder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_raw(cmd_raw), .cmd_dec(cmd_dec), .cmd_len(cmd_len), .ext_cap(ext_cap),
    .region_hdr(region_hdr), .chip_id(chip_id), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rom_off(rom_off), .rom_byte(rom_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last), .mode(mode),
    .data_enc(data_enc));

  function automatic logic [7:0] romf(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction
  assign rom_byte = romf(rd_addr + 32'(rom_off));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_st = 0, m_cnt = 0, m_len = 0, m_src = 0, m_mode = 0;
  logic        m_enc = 1'b0;
  logic [31:0] m_addr = '0;
  string       m_tag = "R1", m_mtag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_mode = 0; m_enc = 0; m_cnt = 0; m_len = 0; m_src = 0;
      m_tag = "R1"; m_mtag = "R1";
    end else if (m_st == 0) begin
      if (cmd_valid) begin
        int op, nb, rom;
        op = int'(cmd_raw[63:56]); nb = int'(cmd_dec[63:60]); rom = 0;
        m_src = 0; m_tag = "R9"; m_mtag = "R9";
        if (m_mode == 0) begin
          if (op == 'h9F) m_tag = "R2";
          else if (op == 'h00) begin m_src = 2; rom = 1; m_addr = 0; m_tag = "R3"; end
          else if (op == 'h90) begin m_src = 1; m_tag = "R4"; end
          else if (op == 'h3C) begin m_mode = 1; m_mtag = "R5"; end
          else if (op == 'h3D) begin m_mtag = "R5"; if (ext_cap) m_mode = 2; end
          else m_mtag = "R6";
        end else if (m_mode == 3) begin
          if (op == 'hB8) begin m_src = 1; m_tag = "R4"; end
          else m_mtag = "R6";
        end else begin
          m_mtag = "R6";
          if (nb == 1) begin m_src = 1; m_tag = "R4"; end
          else if (nb == 2) begin
            logic [31:0] a, base;
            a = {16'h0, cmd_dec[47:40] & 8'hF0, 8'h00};
            base = 32'(region_hdr) << 19;
            if (m_mode == 2) a = a - 32'h1000 + base;
            m_addr = a; m_src = 2; rom = 1; m_tag = "R8";
          end
          else if (nb == 4) begin m_enc = 1; m_mtag = "R7"; end
          else if (nb == 'hA) begin m_mode = 3; m_mtag = "R7"; end
        end
        m_len = int'(cmd_len); m_cnt = 0;
        if (m_len == 0) m_st = 0; else if (rom) m_st = 1; else m_st = 2;
      end
    end else if (m_st == 1) begin
      if (rd_done) m_st = 2;
    end else if (out_ready) begin
      if (m_cnt == m_len - 1) m_st = 0; else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      logic [7:0] eb;
      chk("R10 cmd_ready", cmd_ready, m_st == 0);
      chk("R10 out_valid", out_valid, m_st == 2);
      chk("R11 rd_req", rd_req, m_st == 1);
      chk({m_mtag, " mode"}, mode, m_mode);
      chk("R7 data_enc", data_enc, m_enc);
      if (m_st == 1) chk({m_tag, " rd_addr"}, rd_addr, m_addr);
      if (m_st == 2) begin
        case (m_src)
          1: eb = chip_id[8*(m_cnt%4) +: 8];
          2: eb = romf(m_addr + 32'(m_cnt % 4096));
          default: eb = 8'hFF;
        endcase
        chk({m_tag, " out_byte"}, out_byte, eb);
        chk("R10 out_last", out_last, m_cnt == m_len - 1);
      end
    end
  end

  // ready pattern and ROM responder
  logic [7:0] lfsr = 8'h5B;
  int dly = 0;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = lfsr[0] | lfsr[1];
    if (!rd_req) begin dly = 0; rd_done = 1'b0; end
    else if (rd_done) rd_done = 1'b0;
    else begin dly++; if (dly == 3) rd_done = 1'b1; end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] op, input logic [3:0] nb, input logic [7:0] b2, input int len);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_raw = {op, 56'h0123456789ABCD};
    cmd_dec = {nb, 4'h5, 8'h77, b2, 40'h0};
    cmd_len = 16'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    started = 1'b1;
    chk("R1 reset mode", mode, 2'd0);
    chk("R1 reset data_enc", data_enc, 1'b0);
    chk("R1 reset out_valid", out_valid, 1'b0);
    chk("R1 reset rd_req", rd_req, 1'b0);
    chk("R1 reset cmd_ready", cmd_ready, 1'b1);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    send(8'h9F, 4'h0, 8'h00, 8);       // R2
    send(8'h00, 4'h0, 8'h00, 4104);    // R3 wrap past one block
    send(8'h90, 4'h0, 8'h00, 12);      // R4
    send(8'h90, 4'h0, 8'h00, 0);       // R10 zero length
    chk("R10 zero length idle", {out_valid, cmd_ready}, 2'b01);
    send(8'h55, 4'h1, 8'h00, 4);       // R9 unknown
    chk("R9 unknown keeps raw", mode, 2'd0);
    send(8'h3D, 4'h0, 8'h00, 4);       // R5 no capability
    chk("R5 3D ignored", mode, 2'd0);
    send(8'hA0, 4'hA, 8'h00, 4);       // R6 secure code in raw
    chk("R6 raw ignores dec", mode, 2'd0);
    send(8'hB8, 4'h0, 8'h00, 4);       // R6 main code in raw
    send(8'h3C, 4'h0, 8'h00, 4);       // R5
    chk("R5 enter secure", mode, 2'd1);
    send(8'h9F, 4'h1, 8'h00, 8);       // R6 raw opcode ignored, chip id
    send(8'h00, 4'h2, 8'h5A, 20);      // R8 addr 0x5000
    send(8'h3C, 4'h7, 8'h00, 4);       // R9
    chk("R9 secure unknown", mode, 2'd1);
    send(8'h00, 4'h4, 8'h00, 4);       // R7
    chk("R7 enc set", data_enc, 1'b1);
    send(8'h00, 4'hA, 8'h00, 4);       // R7
    chk("R7 enter main", mode, 2'd3);
    send(8'hB8, 4'h0, 8'h00, 8);       // R4
    send(8'h3C, 4'hA, 8'h00, 4);       // R9
    chk("R9 main locked", mode, 2'd3);
    chk("R7 enc sticky", data_enc, 1'b1);
    do_reset();
    ext_cap = 1'b1;
    send(8'h3D, 4'h0, 8'h00, 4);       // R5
    chk("R5 enter extended", mode, 2'd2);
    send(8'h00, 4'h2, 8'h30, 8);       // R8 0x182000
    send(8'h00, 4'h2, 8'h0F, 6);       // R8 0x17F000
    send(8'h00, 4'h1, 8'h00, 7);       // R4
    send(8'h00, 4'hA, 8'h00, 2);       // R7
    chk("R7 extended to main", mode, 2'd3);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule